// File: doc/BRIEF.md
# Multicart Pattern-Memory Bank Translator

This block turns the cartridge's register state into a 1 KB pattern-memory bank index for whichever of the eight 1 KB picture-processor windows is being accessed. Inner registers are written through the CPU window at 0x8000-0xFFFF: a command byte, eight bank values and a mirroring register. Outer registers are written at 0x5000-0x5FFF. The outer registers pick one of three translation paths. The flat path maps the whole 8 KB as one bank. The raw path passes the inner 1 KB values through unchanged. The based path ORs an outer offset into each value and has an extended variant.

The block also returns the nametable arrangement and the stored command byte, which a neighbouring program-bank translator decodes. All outputs are combinational functions of the registers. A register write is therefore visible on the first access after the clock edge that stores it.

Top module: `chr_bank_xlat`

## Requirements
- R1: After reset, in the based mode with offset 0, windows 0..7 map to banks 0..7 and the arrangement is vertical (`mirror_mode` = 2'b00), or four-screen (2'b10) when FOUR_SCREEN = 1.
- R2: Bank value 0 covers windows 0 and 1, and value 1 covers windows 2 and 3. The even window gets the value with bit 0 cleared and the odd window gets it with bit 0 set. Values 2..5 map windows 4..7 one to one. A value is chosen by writing its index to command bits [2:0] at 0x8000 and the data to 0x8001.
- R3: Command bit 7 swaps the two 4 KB halves: window w uses the mapping that window w XOR 4 would otherwise have.
- R4: With outer register 0 bit 6 set (flat mode), window w reads bank ((outer2 | latch) << 3) | w.
- R5: In flat mode, a CPU write anywhere in 0x8000-0xFFFF loads data[1:0] into the 2-bit latch when outer0 bits [5:4] are 0 and clears it otherwise. Inner registers, including the command byte, are left untouched.
- R6: With outer0 bit 6 clear and bit 5 set (raw mode), the inner 1 KB value is output unmodified, with no offset.
- R7: Otherwise (based mode) outer2[6:0] << 3 is ORed into every window's value, and outer2 bit 7 is ignored.
- R8: In based mode with outer3 bit 1 set, the first four logical windows take bank value 0, extra register A, bank value 1 and extra register B, each unmodified and ORed with the offset. Both extra registers reset to 0xFF.
- R9: A write to 0x8001 while outer3 bit 1 and command bit 3 are set goes to extra register A when command[1:0] = 2, or to extra register B when command[1:0] = 3, and not to a bank value.
- R10: With HAS_CHR_ROM = 0, a command write of 0x46 is stored as 0x47 and 0x47 as 0x46. Other values, and all values when HAS_CHR_ROM = 1, are stored as written.
- R11: Bit 0 of the register at 0xA000 selects horizontal (2'b01) when 1 and vertical (2'b00) when 0. With FOUR_SCREEN = 1 the output stays 2'b10.
- R12: Writes to 0xC000-0xFFFF outside flat mode change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ppu_slot | input | 3 | 1 KB window being accessed (address bits 12:10) |
| chr_bank | output | BANK_W | 1 KB bank index for that window |
| mirror_mode | output | 2 | 00 vertical, 01 horizontal, 10 four-screen |
| inner_cmd | output | 8 | Stored command byte, for the program-bank translator |

## Verification
The bench builds two copies that share one stimulus stream. The first has HAS_CHR_ROM = 0 and FOUR_SCREEN = 0. The second has HAS_CHR_ROM = 1 and FOUR_SCREEN = 1. The pair makes the 0x46/0x47 command swap and its absence observable in the same cycle. It also makes selectable mirroring and forced four-screen observable in the same cycle. Bank checks are identical on both copies, so any path that leaks a board option into the bank computation shows up as a difference.

// File: rtl/chr_bank_xlat.sv
module chr_bank_xlat #(
  parameter bit HAS_CHR_ROM = 1'b1,
  parameter bit FOUR_SCREEN = 1'b0,
  parameter int BANK_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        ppu_slot,
  output logic [BANK_W-1:0] chr_bank,
  output logic [1:0]        mirror_mode,
  output logic [7:0]        inner_cmd
);
  localparam logic [7:0] BANK_INIT [8] = '{8'd0, 8'd2, 8'd4, 8'd5, 8'd6, 8'd7, 8'd0, 8'd1};

  logic [7:0] outer0, outer2, outer3, extra_a, extra_b, cmd, mir_reg;
  logic [7:0] bank_r [8];
  logic [1:0] latch;

  wire        outer_wr = wr_en && (wr_addr[15:12] == 4'h5);
  wire        inner_wr = wr_en && wr_addr[15];
  wire        flat     = outer0[6];
  wire        raw      = !outer0[6] && outer0[5];
  wire [15:0] dec      = wr_addr & 16'hE001;
  wire        extra_wr = inner_wr && !flat && (dec == 16'h8001) && outer3[1] && cmd[3];
  wire [7:0]  cmd_in   = (!HAS_CHR_ROM && (wr_data == 8'h46 || wr_data == 8'h47))
                         ? (wr_data ^ 8'h01) : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outer0  <= 8'h04;
      outer2  <= 8'h00;
      outer3  <= 8'h00;
      extra_a <= 8'hFF;
      extra_b <= 8'hFF;
      cmd     <= 8'h00;
      mir_reg <= 8'h00;
      latch   <= 2'b00;
      for (int i = 0; i < 8; i++) bank_r[i] <= BANK_INIT[i];
    end else begin
      if (outer_wr) begin
        case (wr_addr[1:0])
          2'd0: outer0 <= wr_data;
          2'd2: outer2 <= wr_data;
          2'd3: outer3 <= wr_data;
          default: ;
        endcase
      end
      if (inner_wr) begin
        if (flat) begin
          latch <= (outer0[5:4] == 2'b00) ? wr_data[1:0] : 2'b00;
        end else if (extra_wr) begin
          if (cmd[1:0] == 2'd2) extra_a <= wr_data;
          if (cmd[1:0] == 2'd3) extra_b <= wr_data;
        end else begin
          case (dec)
            16'h8000: cmd <= cmd_in;
            16'h8001: bank_r[cmd[2:0]] <= wr_data;
            16'hA000: mir_reg <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  wire [2:0] lslot = ppu_slot ^ {cmd[7], 2'b00};
  logic [7:0] inner_val, ext_val;

  always_comb begin
    case (lslot)
      3'd0:    inner_val = {bank_r[0][7:1], 1'b0};
      3'd1:    inner_val = {bank_r[0][7:1], 1'b1};
      3'd2:    inner_val = {bank_r[1][7:1], 1'b0};
      3'd3:    inner_val = {bank_r[1][7:1], 1'b1};
      default: inner_val = bank_r[lslot - 3'd2];
    endcase
    case (lslot[1:0])
      2'd0:    ext_val = bank_r[0];
      2'd1:    ext_val = extra_a;
      2'd2:    ext_val = bank_r[1];
      default: ext_val = extra_b;
    endcase
  end

  wire        use_ext  = outer3[1] && !lslot[2];
  wire [10:0] based    = {1'b0, outer2[6:0], 3'b000} | {3'b000, (use_ext ? ext_val : inner_val)};
  wire [10:0] flat_bnk = {(outer2 | {6'b0, latch}), ppu_slot};
  wire [10:0] bank11   = flat ? flat_bnk : (raw ? {3'b000, inner_val} : based);

  assign chr_bank    = BANK_W'(bank11);
  assign mirror_mode = FOUR_SCREEN ? 2'b10 : {1'b0, mir_reg[0]};
  assign inner_cmd   = cmd;
endmodule

// File: rtl/chr_bank_xlat_chk.sv
module chr_bank_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  ppu_slot,
  input logic [10:0] bank_all,
  input logic [1:0]  mirror_mode,
  input logic        mode_flat,
  input logic        mode_raw
);
  AST_FLAT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flat |-> (bank_all[2:0] == ppu_slot)); // R4
  AST_RAW_NO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_raw |-> (bank_all[10:8] == 3'b000)); // R6
  AST_MIRROR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_mode != 2'b11); // R11
  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mirror_mode)); // R11
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(ppu_slot) || $stable(bank_all))); // R12
endmodule

bind chr_bank_xlat chr_bank_xlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ppu_slot(ppu_slot),
  .bank_all(chr_bank[10:0]), .mirror_mode(mirror_mode),
  .mode_flat(flat), .mode_raw(raw)
);

// File: tb/chr_bank_xlat_tb.sv
module chr_bank_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = 16'h0;
  logic [7:0]  wr_data = 8'h0;
  logic [2:0]  ppu_slot = 3'd0;
  logic [10:0] bank_a, bank_b;
  logic [1:0]  mir_a, mir_b;
  logic [7:0]  cmd_a, cmd_b;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chr_bank_xlat #(.HAS_CHR_ROM(1'b0), .FOUR_SCREEN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ppu_slot(ppu_slot), .chr_bank(bank_a), .mirror_mode(mir_a), .inner_cmd(cmd_a));
  chr_bank_xlat #(.HAS_CHR_ROM(1'b1), .FOUR_SCREEN(1'b1)) u_dut_rom (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ppu_slot(ppu_slot), .chr_bank(bank_b), .mirror_mode(mir_b), .inner_cmd(cmd_b));

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmp(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_slot(input string req, input logic [2:0] s, input logic [10:0] exp);
    @(negedge clk); ppu_slot = s; #1;
    cmp({req, " copy A"}, bank_a, exp);
    cmp({req, " copy B"}, bank_b, exp);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 8; s++) chk_slot("R1 reset map", 3'(s), 11'(s));
    cmp("R1 mirror A", 11'(mir_a), 11'd0);
    cmp("R1 mirror B", 11'(mir_b), 11'd2);
  endtask

  task automatic t_pair;
    cpu_wr(16'h8000, 8'h00); cpu_wr(16'h8001, 8'h25);
    cpu_wr(16'h8000, 8'h01); cpu_wr(16'h8001, 8'h30);
    cpu_wr(16'h8000, 8'h05); cpu_wr(16'h8001, 8'h9A);
    chk_slot("R2 even", 3'd0, 11'h24);
    chk_slot("R2 odd",  3'd1, 11'h25);
    chk_slot("R2 even", 3'd2, 11'h30);
    chk_slot("R2 odd",  3'd3, 11'h31);
    chk_slot("R2 single", 3'd7, 11'h9A);
    chk_slot("R2 untouched", 3'd4, 11'h04);
  endtask

  task automatic t_swap;
    cpu_wr(16'h8000, 8'h80);
    chk_slot("R3 swap", 3'd4, 11'h24);
    chk_slot("R3 swap", 3'd5, 11'h25);
    chk_slot("R3 swap", 3'd0, 11'h04);
    chk_slot("R3 swap", 3'd3, 11'h9A);
    cpu_wr(16'h8000, 8'h00);
    chk_slot("R3 unswap", 3'd0, 11'h24);
  endtask

  task automatic t_quirk;
    cpu_wr(16'h8000, 8'h46); #1;
    cmp("R10 0x46 ram", 11'(cmd_a), 11'h47);
    cmp("R10 0x46 rom", 11'(cmd_b), 11'h46);
    cpu_wr(16'h8000, 8'h47); #1;
    cmp("R10 0x47 ram", 11'(cmd_a), 11'h46);
    cmp("R10 0x47 rom", 11'(cmd_b), 11'h47);
    cpu_wr(16'h8000, 8'h45); #1;
    cmp("R10 other", 11'(cmd_a), 11'h45);
    cpu_wr(16'h8000, 8'h00);
  endtask

  task automatic t_mirror;
    cpu_wr(16'hA000, 8'h01); #1;
    cmp("R11 horiz A", 11'(mir_a), 11'd1);
    cmp("R11 four B", 11'(mir_b), 11'd2);
    cpu_wr(16'hA000, 8'h02); #1;
    cmp("R11 vert A", 11'(mir_a), 11'd0);
  endtask

  task automatic t_hi_ignored;
    cpu_wr(16'hC000, 8'hFF); cpu_wr(16'hE001, 8'h12); cpu_wr(16'hC001, 8'h77);
    chk_slot("R12 ignored", 3'd0, 11'h24);
    chk_slot("R12 ignored", 3'd7, 11'h9A);
    cmp("R12 cmd kept", 11'(cmd_a), 11'h00);
  endtask

  task automatic t_base;
    cpu_wr(16'h5002, 8'h85);
    chk_slot("R7 base", 3'd0, 11'h2C);
    chk_slot("R7 base", 3'd1, 11'h2D);
    chk_slot("R7 base", 3'd7, 11'hBA);
  endtask

  task automatic t_ext;
    cpu_wr(16'h5003, 8'h02);
    chk_slot("R8 ext R0 raw", 3'd0, 11'h2D);
    chk_slot("R8 ext A reset", 3'd1, 11'hFF);
    chk_slot("R8 ext R1 raw", 3'd2, 11'h38);
    chk_slot("R8 ext B reset", 3'd3, 11'hFF);
    chk_slot("R8 upper half", 3'd4, 11'h2C);
    cpu_wr(16'h8000, 8'h0A); cpu_wr(16'h8001, 8'h11);
    cpu_wr(16'h8000, 8'h0B); cpu_wr(16'h8001, 8'h40);
    chk_slot("R9 extra A", 3'd1, 11'h39);
    chk_slot("R9 extra B", 3'd3, 11'h68);
    chk_slot("R9 R1 kept", 3'd2, 11'h38);
    cpu_wr(16'h8000, 8'h00);
    cpu_wr(16'h5003, 8'h00);
    chk_slot("R8 off", 3'd1, 11'h2D);
  endtask

  task automatic t_raw;
    cpu_wr(16'h5000, 8'h20);
    chk_slot("R6 raw", 3'd0, 11'h24);
    chk_slot("R6 raw", 3'd7, 11'h9A);
  endtask

  task automatic t_flat;
    cpu_wr(16'h5000, 8'h40);
    chk_slot("R4 flat", 3'd3, 11'h42B);
    cpu_wr(16'h8000, 8'h03);
    chk_slot("R5 latch", 3'd3, 11'h43B);
    cmp("R5 cmd kept", 11'(cmd_a), 11'h00);
    cpu_wr(16'h5000, 8'h50);
    cpu_wr(16'hC000, 8'h02);
    chk_slot("R5 clear", 3'd6, 11'h42E);
    cpu_wr(16'h5000, 8'h40);
    cpu_wr(16'hE000, 8'h02);
    chk_slot("R4 latch or", 3'd0, 11'h438);
    cpu_wr(16'h5000, 8'h04);
    chk_slot("R7 back", 3'd0, 11'h2C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_pair; t_swap; t_quirk; t_mirror; t_hi_ignored;
    t_base; t_ext; t_raw; t_flat;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule